// File: doc/BRIEF.md
# Regulator Startup and Fault Sequencer

This block is the top-level state machine in the digital core of a step-down switching regulator. It decides when the power stage may switch and when the power-good line is released. It watches a bias-supply-good flag, the enable pin, input undervoltage and overvoltage flags, an output overvoltage comparator and an overtemperature flag. It drives a one-cycle strap-sampling strobe, the switching enable, a soft-start flag with a ramp level for the reference ramp, and a pull-low request for the open-drain power-good pin. All intervals are counted in clock cycles and derived from the parameter `CLK_KHZ`: 540 µs initialisation, 200 µs enable-rise filter, 2 µs enable-fall filter, 3 ms soft-start, 2 µs output-overvoltage deglitch and 20 ms hiccup.

The states are OFF, INIT, WAIT, SOFT, RUN and HICCUP. OFF→INIT is taken when the bias supply becomes good. INIT→WAIT is taken when initialisation completes. WAIT→SOFT is taken when the filtered enable is high and no input or thermal fault is present. SOFT→RUN is taken when the ramp completes. SOFT or RUN→WAIT is taken on a filtered disable. SOFT or RUN→HICCUP is taken on a fault. HICCUP→WAIT is taken once the fault has been clear for the whole hiccup interval. Any state goes to OFF on loss of bias. A restart always runs a full new soft-start and does not sample the straps again.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is applied, `sw_en`, `ss_active` and `strap_sample` are 0, `ss_ramp` is 0 and `pg_pull_low` is 1.
- R2: When `bias_ok` rises, `strap_sample` is 1 for exactly the first cycle of initialisation. A hiccup restart or an enable restart does not strobe it again. Only a new bias power-up does.
- R3: Switching starts only after initialisation has lasted INIT_CYC cycles, and only while the filtered enable is high and `vin_uv`, `vin_ov` and `over_temp` are all 0. Once those conditions hold after initialisation, soft-start begins on the next clock edge.
- R4: The filtered enable goes high only after `en_pin` has been high for RISE_CYC consecutive cycles. Shorter high pulses have no effect.
- R5: The filtered enable goes low after `en_pin` has been low for FALL_CYC consecutive cycles, and switching stops in that same cycle. Shorter low pulses have no effect. A disable returns to WAIT without a hiccup delay.
- R6: Soft-start lasts SS_CYC cycles with `ss_active` and `sw_en` high. After k cycles of soft-start, `ss_ramp` equals floor(k·(2^RAMP_W−1)/SS_CYC). It reaches all ones at the end and holds that value while regulating.
- R7: `pg_pull_low` is 0 only while regulating after a completed soft-start with no fault present. It is 1 in every other state.
- R8: A 1 on `vin_uv`, `vin_ov` or `over_temp` during soft-start or regulation clears `sw_en` and sets `pg_pull_low` in the same cycle, and the block enters HICCUP.
- R9: `vout_ov` is ignored during soft-start. While regulating, it stops switching once it has been 1 for OVP_CYC consecutive cycles. Shorter pulses have no effect.
- R10: In HICCUP, a new soft-start begins HIC_CYC+1 clock edges after the last cycle in which any fault input (including `vout_ov`) was 1. A fault that reappears restarts the interval.
- R11: A 0 on `bias_ok` clears `sw_en` and sets `pg_pull_low` in the same cycle from any state, and the block returns to OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; its frequency is the parameter `CLK_KHZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| bias_ok | input | 1 | Bias supply above its rising lockout threshold |
| en_pin | input | 1 | Enable pin, already synchronised |
| vin_uv | input | 1 | Input supply below its undervoltage threshold |
| vin_ov | input | 1 | Input supply above its overvoltage threshold |
| vout_ov | input | 1 | Raw output overvoltage comparator |
| over_temp | input | 1 | Junction overtemperature flag |
| strap_sample | output | 1 | One-cycle strobe for latching the configuration straps |
| sw_en | output | 1 | Power stage may switch |
| ss_active | output | 1 | Soft-start ramp in progress |
| ss_ramp | output | RAMP_W | Soft-start ramp level, 0 up to all ones |
| pg_pull_low | output | 1 | 1 = pull the open-drain power-good line low |

## Verification
On every cycle, the assertions check the following relations: fault and bias-loss inputs force switching off at once, switching never runs without the filtered enable, the ramp never falls during soft-start, power-good is released only at full ramp with no fault, and the strap strobe is a single pulse. Other behaviour depends on exact cycle counts, and only the bench scenarios can show it. This covers the initialisation length, the two enable filter delays, the overvoltage deglitch window and its masking during soft-start, the hiccup interval restarting on a repeated fault, and the fact that no new strap strobe appears on a restart.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_INIT,
        ST_WAIT,
        ST_SOFT,
        ST_RUN,
        ST_HICCUP
    } seq_state_t;

    // Converts an interval in nanoseconds to clock cycles, never less than one.
    function automatic int unsigned ns_to_cycles(longint unsigned clk_khz,
                                                 longint unsigned ns);
        longint unsigned c;
        c = (ns * clk_khz) / 64'd1000000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_seq_enfilt.sv
// Asymmetric enable filter: output follows input only after the input has
// disagreed with it for a direction-dependent number of consecutive cycles.
module pwr_seq_enfilt #(
    parameter int unsigned RISE_CYC = 200,
    parameter int unsigned FALL_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_raw,
    output logic en_filt
);
    localparam int unsigned MAXC  = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
    localparam int          CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] RISE_LIM = CNT_W'(RISE_CYC - 1);
    localparam logic [CNT_W-1:0] FALL_LIM = CNT_W'(FALL_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             filt_q;
    logic [CNT_W-1:0] lim;

    always_comb lim = filt_q ? FALL_LIM : RISE_LIM;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            filt_q <= 1'b0;
        end else if (en_raw == filt_q) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            filt_q <= en_raw;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign en_filt = filt_q;
endmodule

// File: rtl/pwr_seq_timer.sv
// Saturating elapsed-cycle counter with synchronous clear.
module pwr_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] elapsed
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) elapsed <= '0;
        else if (elapsed != {W{1'b1}}) elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/pwr_seq_ovpmon.sv
// Output overvoltage deglitch: trips after DG_CYC consecutive armed cycles high.
module pwr_seq_ovpmon #(
    parameter int unsigned DG_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ovp_raw,
    output logic trip
);
    localparam int CNT_W = $clog2(DG_CYC + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(DG_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !ovp_raw) cnt <= '0;
        else if (cnt != LIM)            cnt <= cnt + 1'b1;
    end

    assign trip = arm && (cnt == LIM);
endmodule

// File: rtl/pwr_seq_ramp.sv
// Soft-start ramp: spreads 2^RW-1 level steps evenly over SS_CYC cycles using
// a remainder accumulator (requires SS_CYC >= 2^RW-1).
module pwr_seq_ramp #(
    parameter int unsigned SS_CYC = 3000,
    parameter int          RW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [RW-1:0] level
);
    localparam int AW = $clog2(2 * SS_CYC + 1);
    localparam logic [AW-1:0] STEP_V = AW'((1 << RW) - 1);
    localparam logic [AW-1:0] SS_V   = AW'(SS_CYC);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;

    always_comb sum = acc + STEP_V;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc   <= '0;
            level <= '0;
        end else if (step) begin
            if (sum >= SS_V) begin
                acc <= sum - SS_V;
                if (level != {RW{1'b1}}) level <= level + 1'b1;
            end else begin
                acc <= sum;
            end
        end
    end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 125000,
    parameter int          RAMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bias_ok,
    input  logic              en_pin,
    input  logic              vin_uv,
    input  logic              vin_ov,
    input  logic              vout_ov,
    input  logic              over_temp,
    output logic              strap_sample,
    output logic              sw_en,
    output logic              ss_active,
    output logic [RAMP_W-1:0] ss_ramp,
    output logic              pg_pull_low
);
    localparam int unsigned INIT_CYC = ns_to_cycles(CLK_KHZ, 540000);
    localparam int unsigned RISE_CYC = ns_to_cycles(CLK_KHZ, 200000);
    localparam int unsigned FALL_CYC = ns_to_cycles(CLK_KHZ, 2000);
    localparam int unsigned SS_CYC   = ns_to_cycles(CLK_KHZ, 3000000);
    localparam int unsigned OVP_CYC  = ns_to_cycles(CLK_KHZ, 2000);
    localparam int unsigned HIC_CYC  = ns_to_cycles(CLK_KHZ, 20000000);
    localparam int unsigned MAX_CYC  = max_u(max_u(INIT_CYC, SS_CYC), HIC_CYC);
    localparam int          TMR_W    = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] INIT_LIM = TMR_W'(INIT_CYC - 1);
    localparam logic [TMR_W-1:0] SS_LIM   = TMR_W'(SS_CYC - 1);
    localparam logic [TMR_W-1:0] HIC_LIM  = TMR_W'(HIC_CYC - 1);

    seq_state_t       state, nxt;
    logic             en_filt;
    logic             ovp_trip;
    logic [TMR_W-1:0] elapsed;
    logic             in_fault;
    logic             hic_hold;
    logic             stop_now;
    logic             tmr_clr;
    logic             ramp_clr;
    logic             ramp_step;

    pwr_seq_enfilt #(.RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)) u_enfilt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_raw (en_pin),
        .en_filt(en_filt)
    );

    pwr_seq_ovpmon #(.DG_CYC(OVP_CYC)) u_ovpmon (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (state == ST_RUN),
        .ovp_raw(vout_ov),
        .trip   (ovp_trip)
    );

    pwr_seq_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .elapsed(elapsed)
    );

    pwr_seq_ramp #(.SS_CYC(SS_CYC), .RW(RAMP_W)) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ramp_clr),
        .step (ramp_step),
        .level(ss_ramp)
    );

    always_comb begin
        in_fault = vin_uv || vin_ov || over_temp;
        hic_hold = in_fault || vout_ov;
        stop_now = !bias_ok || !en_filt || in_fault || ovp_trip;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (bias_ok) nxt = ST_INIT;
            ST_INIT:   if (!bias_ok)                nxt = ST_OFF;
                       else if (elapsed == INIT_LIM) nxt = ST_WAIT;
            ST_WAIT:   if (!bias_ok)                   nxt = ST_OFF;
                       else if (en_filt && !in_fault)  nxt = ST_SOFT;
            ST_SOFT:   if (!bias_ok)                 nxt = ST_OFF;
                       else if (in_fault)            nxt = ST_HICCUP;
                       else if (!en_filt)            nxt = ST_WAIT;
                       else if (elapsed == SS_LIM)   nxt = ST_RUN;
            ST_RUN:    if (!bias_ok)                 nxt = ST_OFF;
                       else if (in_fault || ovp_trip) nxt = ST_HICCUP;
                       else if (!en_filt)            nxt = ST_WAIT;
            ST_HICCUP: if (!bias_ok)                            nxt = ST_OFF;
                       else if (!hic_hold && elapsed == HIC_LIM) nxt = ST_WAIT;
            default:   nxt = ST_OFF;
        endcase
    end

    always_comb tmr_clr = (nxt != state) || (state == ST_HICCUP && hic_hold);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Outputs
    always_comb begin
        strap_sample = 1'b0;
        sw_en        = 1'b0;
        ss_active    = 1'b0;
        pg_pull_low  = 1'b1;
        ramp_clr     = 1'b1;
        ramp_step    = 1'b0;
        unique case (state)
            ST_OFF:    ;
            ST_INIT:   strap_sample = (elapsed == '0);
            ST_WAIT:   ;
            ST_SOFT: begin
                sw_en     = !stop_now;
                ss_active = !stop_now;
                ramp_clr  = 1'b0;
                ramp_step = 1'b1;
            end
            ST_RUN: begin
                sw_en       = !stop_now;
                pg_pull_low = stop_now;
                ramp_clr    = 1'b0;
            end
            ST_HICCUP: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
    parameter int RAMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bias_ok,
    input logic              vin_uv,
    input logic              vin_ov,
    input logic              over_temp,
    input logic              en_filt,
    input logic              strap_sample,
    input logic              sw_en,
    input logic              ss_active,
    input logic [RAMP_W-1:0] ss_ramp,
    input logic              pg_pull_low
);
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strap_sample |=> !strap_sample);

    p_sw_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> en_filt);

    p_ss_implies_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> sw_en);

    p_ramp_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |=> (!ss_active || ss_ramp >= $past(ss_ramp)));

    p_pg_full_ramp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_pull_low |-> (sw_en && !ss_active && ss_ramp == {RAMP_W{1'b1}}));

    p_fault_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vin_uv || vin_ov || over_temp) |-> (!sw_en && pg_pull_low));

    p_bias_loss_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_ok |-> (!sw_en && pg_pull_low));
endmodule

bind pwr_seq_top pwr_seq_checker #(.RAMP_W(RAMP_W)) u_chk (.*);

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;
    // Scaled time base: the design is told its clock is 1 MHz so that the
    // millisecond intervals fit a short run; the bench clock toggles at 125 MHz.
    localparam int unsigned BCLK_KHZ = 1000;
    localparam int          RW       = 8;

    function automatic int cyc_of(longint ns);
        longint c;
        c = (ns * BCLK_KHZ) / 1000000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    function automatic int exp_ramp(int k, int ss);
        return (k * ((1 << RW) - 1)) / ss;
    endfunction

    localparam int T_INIT = 540;
    localparam int T_RISE = 200;
    localparam int T_FALL = 2;
    localparam int T_SS   = 3000;
    localparam int T_OVP  = 2;
    localparam int T_HIC  = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bias_ok = 1'b0, en_pin = 1'b0, vin_uv = 1'b0, vin_ov = 1'b0;
    logic vout_ov = 1'b0, over_temp = 1'b0;
    logic strap_sample, sw_en, ss_active, pg_pull_low;
    logic [RW-1:0] ss_ramp;

    int checks = 0;
    int errors = 0;
    int strap_cnt = 0;

    always #4 clk = ~clk;

    pwr_seq_top #(.CLK_KHZ(BCLK_KHZ), .RAMP_W(RW)) u_pwr_seq_top (
        .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .en_pin(en_pin),
        .vin_uv(vin_uv), .vin_ov(vin_ov), .vout_ov(vout_ov),
        .over_temp(over_temp), .strap_sample(strap_sample), .sw_en(sw_en),
        .ss_active(ss_active), .ss_ramp(ss_ramp), .pg_pull_low(pg_pull_low)
    );

    always @(negedge clk) if (rst_n && strap_sample) strap_cnt++;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Called just after soft-start entry; returns just after RUN entry.
    task automatic soft_start(input bit inject_ovp);
        int bad_ramp = 0, bad_flag = 0, first_k = -1, first_v = 0;
        chk("R6", "ramp at soft-start entry", ss_ramp, 0);
        chk("R7", "pg during soft-start", pg_pull_low, 1);
        for (int k = 1; k < T_SS; k++) begin
            if (inject_ovp && k == 10) vout_ov = 1'b1;
            if (inject_ovp && k == 40) vout_ov = 1'b0;
            tick(1);
            if (int'(ss_ramp) != exp_ramp(k, T_SS)) begin
                bad_ramp++;
                if (first_k < 0) begin first_k = k; first_v = ss_ramp; end
            end
            if (!ss_active || !sw_en) bad_flag++;
        end
        if (first_k >= 0)
            $display("FAIL R6 ramp at step %0d: actual %0d expected %0d",
                     first_k, first_v, exp_ramp(first_k, T_SS));
        checks++; if (bad_ramp != 0) errors++;
        chk(inject_ovp ? "R9" : "R6", "cycles with soft-start dropped", bad_flag, 0);
        tick(1);
        chk("R6", "ss_active after ramp", ss_active, 0);
        chk("R6", "ramp held at full", ss_ramp, (1 << RW) - 1);
        chk("R7", "pg released in regulation", pg_pull_low, 0);
        chk("R7", "switching in regulation", sw_en, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "sw_en in reset", sw_en, 0);
        chk("R1", "pg in reset", pg_pull_low, 1);
        chk("R1", "ss_active in reset", ss_active, 0);
        chk("R1", "strobe in reset", strap_sample, 0);
        chk("R1", "ramp in reset", ss_ramp, 0);
        rst_n = 1'b1;

        en_pin = 1'b1;
        tick(T_RISE + 2);
        chk("R3", "no switching without bias", sw_en, 0);

        bias_ok = 1'b1;
        tick(1);
        chk("R2", "strobe in first init cycle", strap_sample, 1);
        tick(1);
        chk("R2", "strobe single cycle", strap_sample, 0);
        tick(T_INIT - 2);
        chk("R3", "no switching in last init cycle", sw_en, 0);
        tick(1);
        chk("R3", "waiting one cycle after init", ss_active, 0);
        tick(1);
        chk("R3", "soft-start begins", ss_active, 1);
        soft_start(1'b0);

        // Random short output overvoltage pulses in regulation
        for (int i = 0; i < 8; i++) begin
            vout_ov = 1'b1;
            tick($urandom_range(T_OVP - 1, 1));
            chk("R9", "short overvoltage ignored", sw_en, 1);
            vout_ov = 1'b0;
            tick(1 + $urandom_range(5, 0));
        end
        chk("R9", "pg after short overvoltage pulses", pg_pull_low, 0);

        // Short enable drops
        for (int i = 0; i < 4; i++) begin
            en_pin = 1'b0;
            tick($urandom_range(T_FALL - 1, 1));
            chk("R5", "short enable drop ignored", sw_en, 1);
            en_pin = 1'b1;
            tick(2);
        end

        // Overtemperature fault, hiccup restarted by a repeat fault
        over_temp = 1'b1;
        #1;
        chk("R8", "overtemp stops switching at once", sw_en, 0);
        chk("R8", "overtemp pulls pg low", pg_pull_low, 1);
        tick(50);
        over_temp = 1'b0;
        tick(100);
        chk("R10", "still in hiccup", sw_en, 0);
        over_temp = 1'b1;
        tick(3);
        over_temp = 1'b0;
        tick(T_HIC);
        chk("R10", "no restart before hiccup ends", ss_active, 0);
        tick(1);
        chk("R10", "restart after hiccup", ss_active, 1);
        chk("R2", "no strobe on restart", strap_cnt, 1);
        soft_start(1'b1);

        // Sustained output overvoltage trips
        vout_ov = 1'b1;
        tick(T_OVP - 1);
        chk("R9", "before deglitch ends", sw_en, 1);
        tick(1);
        chk("R9", "overvoltage trips", sw_en, 0);
        chk("R9", "overvoltage pulls pg low", pg_pull_low, 1);
        tick(10);
        vout_ov = 1'b0;
        tick(T_HIC);
        chk("R10", "no restart before hiccup ends (ovp)", ss_active, 0);
        tick(1);
        chk("R10", "restart after ovp hiccup", ss_active, 1);
        soft_start(1'b0);

        // Disable
        en_pin = 1'b0;
        tick(T_FALL - 1);
        chk("R5", "before fall filter ends", sw_en, 1);
        tick(1);
        chk("R5", "disable stops switching", sw_en, 0);
        chk("R7", "pg low after disable", pg_pull_low, 1);
        tick(1);
        for (int i = 0; i < 4; i++) begin
            en_pin = 1'b1;
            tick($urandom_range(T_RISE - 1, 1));
            en_pin = 1'b0;
            tick(3);
            chk("R4", "short enable pulse ignored", sw_en, 0);
        end
        vin_uv = 1'b1;
        en_pin = 1'b1;
        tick(T_RISE + 3);
        chk("R3", "undervoltage blocks start", sw_en, 0);
        vin_uv = 1'b0;
        tick(1);
        chk("R3", "start once undervoltage clears", ss_active, 1);

        // Input overvoltage during soft-start
        tick(20);
        vin_ov = 1'b1;
        #1;
        chk("R8", "input overvoltage stops switching", sw_en, 0);
        tick(1);
        vin_ov = 1'b0;
        tick(T_HIC);
        chk("R10", "hiccup after input overvoltage", sw_en, 0);
        tick(1);
        chk("R10", "restart after input overvoltage", ss_active, 1);

        // Bias loss
        tick(5);
        bias_ok = 1'b0;
        #1;
        chk("R11", "bias loss stops switching", sw_en, 0);
        chk("R11", "bias loss pg low", pg_pull_low, 1);
        tick(5);
        chk("R11", "stays off without bias", ss_active, 0);
        bias_ok = 1'b1;
        tick(1);
        chk("R2", "new power-up strobes again", strap_sample, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule